// File: doc/BRIEF.md
# Power-Fail Supervisor with Crowbar Latch

This block turns raw power-supply sense signals into the status lines a computer needs to survive power loss. It watches a mains-low comparator, one undervoltage and one overvoltage comparator per output rail, and a set of normally-closed thermal switches. It also senses a power-good line shared by several machines. Any local fault pulls that shared line low through an open-drain style pull-down output, so each machine sees the faults of all the others.

The CPU-facing power-up signal is held low for a fixed hold period after any loss of power-good. A dropout of a single reference-clock cycle still gives the CPU the full interval to run its shutdown routine. Undervoltage, mains-low and thermal faults clear by themselves once the condition goes away. An overvoltage on any rail fires the crowbar and inhibits the preregulator, and this state stays latched until power-on reset. The block runs on a slow reference clock, and the hold period is a cycle-count parameter (default 16384 cycles, 0.5 s at 32.768 kHz).

Top module: `pwr_fail_supervisor`

## Requirements
- R1: While rst_ni is low, power_up_o is 0, pg_pull_low_o is 1, crowbar_o is 0 and prereg_inhibit_o is 0.
- R2: With all inputs healthy after reset, pg_pull_low_o is 0 and power_up_o rises after a full HOLD_CYC low period.
- R3: pg_pull_low_o is 1 when line_low_i is 1, when any bit of rail_uv_i is 1, or when any bit of temp_ok_i is 0 (a 0 means that thermal switch is open).
- R4: When power-good is lost (a local fault, or pg_bus_i at 0), power_up_o falls three clock edges after the input change. It then stays low for exactly HOLD_CYC cycles, even if the dropout lasted one cycle.
- R5: A new dropout that starts and ends inside the hold period does not lengthen it.
- R6: If power-good is still lost when the hold period ends, power_up_o stays low until power-good returns. A fresh full HOLD_CYC period then follows, so it rises HOLD_CYC+3 edges after the fault input clears.
- R7: Mains-low, undervoltage and thermal faults clear by themselves: pg_pull_low_o returns to 0 once the inputs are healthy again.
- R8: A 1 on any bit of rail_ov_i sets crowbar_o and prereg_inhibit_o three edges later and forces pg_pull_low_o to 1. All three stay in that state after rail_ov_i clears, until rst_ni is asserted.
- R9: A low pg_bus_i from another machine starts the power_up_o hold period but does not make pg_pull_low_o go to 1.
- R10: Every sense input passes through a two-flop synchroniser. A change reaches pg_pull_low_o after exactly two clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset; the only way to clear the crowbar latch |
| line_low_i | input | 1 | Mains below threshold (1 = fault) |
| rail_uv_i | input | N_RAILS | Per-rail undervoltage (1 = fault) |
| temp_ok_i | input | N_TEMP | Thermal switches (1 = closed, 0 = open, fault) |
| rail_ov_i | input | N_RAILS | Per-rail overvoltage (1 = fault) |
| pg_bus_i | input | 1 | Sensed level of the shared wired power-good line |
| pg_pull_low_o | output | 1 | Pull-down enable for the shared power-good line (1 = drive low) |
| power_up_o | output | 1 | Power-up status to the CPU (1 = power good, run) |
| prereg_inhibit_o | output | 1 | Preregulator inhibit |
| crowbar_o | output | 1 | Crowbar trigger |

## Verification
A wrong synchroniser depth or fault equation shows as pg_pull_low_o changing one edge early or late. It can also show as a thermal or rail bit that never pulls the line low, and either is visible within three cycles of the stimulus. A hold counter that is wrong, or that restarts on later glitches, shows as a low time on power_up_o that differs from HOLD_CYC. The bench measures that low time to the cycle. A crowbar latch that leaks shows as crowbar_o or prereg_inhibit_o dropping after the overvoltage input clears, long before the next power-on reset.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    PU_WAIT = 2'd0,  // power-good absent, waiting for it to return
    PU_HOLD = 2'd1,  // fixed low period running
    PU_RUN  = 2'd2   // power_up asserted
  } pu_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfs_fault_eval.sv
module pfs_fault_eval #(
  parameter int unsigned N_RAILS = 2,
  parameter int unsigned N_TEMP  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_low_s_i,
  input  logic [N_RAILS-1:0] rail_uv_s_i,
  input  logic [N_TEMP-1:0]  temp_ok_s_i,
  input  logic [N_RAILS-1:0] rail_ov_s_i,
  input  logic               pg_bus_s_i,
  output logic               local_fault_o,
  output logic               pg_ok_o,
  output logic               ov_latched_o
);
  logic recov_fault;
  logic ov_now;
  logic ov_q;

  assign recov_fault = line_low_s_i | (|rail_uv_s_i) | ~(&temp_ok_s_i);
  assign ov_now      = |rail_ov_s_i;

  // sticky until power-on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ov_q <= 1'b0;
    else if (ov_now) ov_q <= 1'b1;
  end

  assign local_fault_o = recov_fault | ov_now | ov_q;
  assign pg_ok_o       = ~local_fault_o & pg_bus_s_i;
  assign ov_latched_o  = ov_q;
endmodule

// File: rtl/pfs_hold_timer.sv
module pfs_hold_timer
  import pfs_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_ok_i,
  output logic power_up_o
);
  localparam int unsigned CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

  pu_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PU_RUN: begin
        if (!pg_ok_i) begin
          state_d = PU_HOLD;
          cnt_d   = '0;
        end
      end
      PU_HOLD: begin
        // level of pg_ok is only looked at on expiry
        if (cnt_q == CNT_LAST) begin
          state_d = pg_ok_i ? PU_RUN : PU_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PU_WAIT: begin
        if (pg_ok_i) begin
          state_d = PU_HOLD;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = PU_WAIT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PU_WAIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign power_up_o = (state_q == PU_RUN);
endmodule

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor #(
  parameter int unsigned N_RAILS     = 2,
  parameter int unsigned N_TEMP      = 2,
  parameter int unsigned HOLD_CYC    = 16384,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_low_i,
  input  logic [N_RAILS-1:0] rail_uv_i,
  input  logic [N_TEMP-1:0]  temp_ok_i,
  input  logic [N_RAILS-1:0] rail_ov_i,
  input  logic               pg_bus_i,
  output logic               pg_pull_low_o,
  output logic               power_up_o,
  output logic               prereg_inhibit_o,
  output logic               crowbar_o
);
  localparam int unsigned SW = 2 + 2 * N_RAILS + N_TEMP;
  // reset value: line low, rails under, thermals open, no overvoltage, bus low
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {N_RAILS{1'b1}}, {N_TEMP{1'b0}},
                                        {N_RAILS{1'b0}}, 1'b0};

  logic [SW-1:0]      raw_vec, sync_vec;
  logic               line_low_s, pg_bus_s;
  logic [N_RAILS-1:0] rail_uv_s, rail_ov_s;
  logic [N_TEMP-1:0]  temp_ok_s;
  logic               local_fault, pg_ok, ov_latched;

  assign raw_vec = {line_low_i, rail_uv_i, temp_ok_i, rail_ov_i, pg_bus_i};

  pfs_sync #(
    .W      (SW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  assign {line_low_s, rail_uv_s, temp_ok_s, rail_ov_s, pg_bus_s} = sync_vec;

  pfs_fault_eval #(
    .N_RAILS(N_RAILS),
    .N_TEMP (N_TEMP)
  ) i_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_low_s_i (line_low_s),
    .rail_uv_s_i  (rail_uv_s),
    .temp_ok_s_i  (temp_ok_s),
    .rail_ov_s_i  (rail_ov_s),
    .pg_bus_s_i   (pg_bus_s),
    .local_fault_o(local_fault),
    .pg_ok_o      (pg_ok),
    .ov_latched_o (ov_latched)
  );

  pfs_hold_timer #(
    .HOLD_CYC(HOLD_CYC)
  ) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pg_ok_i   (pg_ok),
    .power_up_o(power_up_o)
  );

  assign pg_pull_low_o    = local_fault;
  assign crowbar_o        = ov_latched;
  assign prereg_inhibit_o = ov_latched;
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk #(
  parameter int unsigned N_RAILS  = 2,
  parameter int unsigned N_TEMP   = 2,
  parameter int unsigned HOLD_CYC = 16384
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               line_low_i,
  input logic [N_RAILS-1:0] rail_uv_i,
  input logic [N_TEMP-1:0]  temp_ok_i,
  input logic [N_RAILS-1:0] rail_ov_i,
  input logic               pg_ok,
  input logic               pg_pull_low_o,
  input logic               power_up_o,
  input logic               prereg_inhibit_o,
  input logic               crowbar_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_cnt <= '0;
    else if (power_up_o)                  low_cnt <= '0;
    else if (low_cnt != CMAX)             low_cnt <= low_cnt + 1'b1;
  end

  // R3
  recov_fault_pulls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_low_i || (|rail_uv_i) || !(&temp_ok_i)) |-> ##2 pg_pull_low_o);

  // R4
  pg_loss_drops_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_up_o && !pg_ok) |=> !power_up_o);

  // R4
  hold_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(power_up_o) |-> (low_cnt >= CW'(HOLD_CYC)));

  // R8
  ov_fires_crowbar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rail_ov_i) |-> ##3 crowbar_o);

  // R8
  crowbar_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crowbar_o |=> crowbar_o);

  // R8
  crowbar_side_effects_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crowbar_o |-> (prereg_inhibit_o && pg_pull_low_o && !power_up_o));
endmodule

bind pwr_fail_supervisor pfs_chk #(
  .N_RAILS (N_RAILS),
  .N_TEMP  (N_TEMP),
  .HOLD_CYC(HOLD_CYC)
) i_pfs_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .line_low_i      (line_low_i),
  .rail_uv_i       (rail_uv_i),
  .temp_ok_i       (temp_ok_i),
  .rail_ov_i       (rail_ov_i),
  .pg_ok           (pg_ok),
  .pg_pull_low_o   (pg_pull_low_o),
  .power_up_o      (power_up_o),
  .prereg_inhibit_o(prereg_inhibit_o),
  .crowbar_o       (crowbar_o)
);

// File: tb/test_pwr_fail_supervisor.sv
module test_pwr_fail_supervisor;
  localparam int unsigned HOLD = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_low_i = 1'b0;
  logic [1:0] rail_uv_i = 2'b00;
  logic [1:0] temp_ok_i = 2'b11;
  logic [1:0] rail_ov_i = 2'b00;
  logic       pg_bus_i = 1'b1;
  logic       pg_pull_low_o, power_up_o, prereg_inhibit_o, crowbar_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwr_fail_supervisor #(
    .N_RAILS(2), .N_TEMP(2), .HOLD_CYC(HOLD), .SYNC_STAGES(2)
  ) i_pwr_fail_supervisor (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_low_i(line_low_i),
    .rail_uv_i(rail_uv_i), .temp_ok_i(temp_ok_i), .rail_ov_i(rail_ov_i),
    .pg_bus_i(pg_bus_i), .pg_pull_low_o(pg_pull_low_o), .power_up_o(power_up_o),
    .prereg_inhibit_o(prereg_inhibit_o), .crowbar_o(crowbar_o)
  );

  // {line_low, rail_uv[1:0], temp_ok[1:0], pg_bus, expected pg_pull_low}
  // R3 faults, R9 foreign bus low, R7 recovery
  localparam logic [6:0] VEC [10] = '{
    7'b0_00_11_1_0, 7'b1_00_11_1_1, 7'b0_01_11_1_1, 7'b0_10_11_1_1,
    7'b0_00_10_1_1, 7'b0_00_01_1_1, 7'b1_11_00_1_1, 7'b0_00_11_0_0,
    7'b0_01_11_0_1, 7'b0_00_11_1_0
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic healthy();
    line_low_i = 1'b0; rail_uv_i = 2'b00; temp_ok_i = 2'b11;
    rail_ov_i = 2'b00; pg_bus_i = 1'b1;
  endtask

  // counts negedges until power_up_o is high (limit guards a hang)
  task automatic wait_up(output int n);
    n = 0;
    while (!power_up_o && n < 1000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin
    int n, fall_at, rise_at;
    bit saw_low;
    @(negedge clk_i);
    // R1
    chk(power_up_o == 1'b0, "R1 power_up in reset", power_up_o, 0);
    chk(pg_pull_low_o == 1'b1, "R1 pg_pull_low in reset", pg_pull_low_o, 1);
    chk(crowbar_o == 1'b0 && prereg_inhibit_o == 1'b0, "R1 crowbar in reset",
        crowbar_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2: pg ok after edge 2, hold entered edge 3, rise at edge 3+HOLD
    wait_up(n);
    chk(n == HOLD + 3, "R2 first rise delay", n, HOLD + 3);
    chk(pg_pull_low_o == 1'b0, "R2 pg released", pg_pull_low_o, 0);

    // table walk: R3 R7 R9
    for (int i = 0; i < 10; i++) begin
      {line_low_i, rail_uv_i, temp_ok_i, pg_bus_i} = VEC[i][6:1];
      repeat (3) @(negedge clk_i);
      if (!VEC[i][1])      chk(pg_pull_low_o == VEC[i][0], "R9 table", pg_pull_low_o, VEC[i][0]);
      else if (VEC[i][0])  chk(pg_pull_low_o == VEC[i][0], "R3 table", pg_pull_low_o, VEC[i][0]);
      else                 chk(pg_pull_low_o == VEC[i][0], "R7 table", pg_pull_low_o, VEC[i][0]);
    end
    healthy();
    wait_up(n);
    chk(power_up_o == 1'b1, "R7 power_up back", power_up_o, 1);

    // R10 + R4: one-cycle mains dropout
    line_low_i = 1'b1;
    @(negedge clk_i);
    line_low_i = 1'b0;
    chk(pg_pull_low_o == 1'b0, "R10 not after one edge", pg_pull_low_o, 0);
    @(negedge clk_i);
    chk(pg_pull_low_o == 1'b1, "R10 after two edges", pg_pull_low_o, 1);
    fall_at = 0; rise_at = 0; saw_low = 1'b0;
    for (int k = 3; k <= 40; k++) begin
      @(negedge clk_i);
      if (!power_up_o && !saw_low) begin fall_at = k; saw_low = 1'b1; end
      if (power_up_o && saw_low && rise_at == 0) rise_at = k;
    end
    chk(fall_at == 3, "R4 fall edge", fall_at, 3);
    chk(rise_at - fall_at == HOLD, "R4 low length", rise_at - fall_at, HOLD);

    // R5: second dropout inside the hold period
    line_low_i = 1'b1;
    @(negedge clk_i);
    line_low_i = 1'b0;
    fall_at = 0; rise_at = 0; saw_low = 1'b0;
    for (int k = 2; k <= 40; k++) begin
      @(negedge clk_i);
      if (k == 8)  rail_uv_i = 2'b10;
      if (k == 10) rail_uv_i = 2'b00;
      if (!power_up_o && !saw_low) begin fall_at = k; saw_low = 1'b1; end
      if (power_up_o && saw_low && rise_at == 0) rise_at = k;
    end
    chk(rise_at - fall_at == HOLD, "R5 hold not extended", rise_at - fall_at, HOLD);

    // R6: fault outlasts the hold period
    temp_ok_i = 2'b01;
    repeat (40) @(negedge clk_i);
    chk(power_up_o == 1'b0, "R6 held low past expiry", power_up_o, 0);
    temp_ok_i = 2'b11;
    wait_up(n);
    chk(n == HOLD + 3, "R6 fresh full period", n, HOLD + 3);

    // R9: foreign bus dropout
    pg_bus_i = 1'b0;
    repeat (3) @(negedge clk_i);
    pg_bus_i = 1'b1;
    chk(power_up_o == 1'b0, "R9 power_up drops", power_up_o, 1'b0);
    chk(pg_pull_low_o == 1'b0, "R9 no own pull", pg_pull_low_o, 0);
    wait_up(n);

    // R8: overvoltage latch
    rail_ov_i = 2'b10;
    repeat (2) @(negedge clk_i);
    chk(pg_pull_low_o == 1'b1, "R8 pg pulled", pg_pull_low_o, 1);
    @(negedge clk_i);
    chk(crowbar_o == 1'b1, "R8 crowbar fires", crowbar_o, 1);
    chk(prereg_inhibit_o == 1'b1, "R8 inhibit", prereg_inhibit_o, 1);
    rail_ov_i = 2'b00;
    repeat (60) @(negedge clk_i);
    chk(crowbar_o == 1'b1 && prereg_inhibit_o == 1'b1, "R8 latched", crowbar_o, 1);
    chk(pg_pull_low_o == 1'b1 && power_up_o == 1'b0, "R8 no recovery",
        power_up_o, 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(crowbar_o == 1'b0 && prereg_inhibit_o == 1'b0, "R8 R1 reset clears",
        crowbar_o, 0);
    chk(power_up_o == 1'b0, "R1 power_up in second reset", power_up_o, 0);
    rst_ni = 1'b1;
    wait_up(n);
    chk(n == HOLD + 3, "R2 rise after second reset", n, HOLD + 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule